// File: doc/BRIEF.md
# Floating-Point Deferred-Trap Gatekeeper

This block sits beside the decode stage of a 32-bit RISC core and decides, one decoded instruction per cycle, whether a floating-point related instruction may proceed. Every instruction arrives as a class code together with its address and instruction word. The block answers with exactly one of three single-cycle pulses: pass, fp-disabled trap, or fp-exception trap. It also owns the trap-type field of the floating-point status register and a small deferred queue of faulting floating-point operations.

Floating-point exceptions are handled lazily. An exception reported by the arithmetic unit does not trap at once. The gatekeeper only remembers that a trap is owed. The next floating-point operate instruction takes the trap and is recorded in the deferred queue. From then on, only stores may pass until trap software has drained the queue with store-queue instructions. Any other floating-point instruction in that window is refused with a sequence-error code. A cleared enable bit overrides all of this: any floating-point instruction then takes the disabled trap.

Top module: `fpu_defer_ctrl`

## Requirements
- R1: After a synchronous reset the controller is in execute mode (`fpu_state` 0), the queue is empty (`fsr_qne` 0), `fsr_ftt` is 0, `q_overflow` is 0 and no verdict pulse is high.
- R2: In execute mode (state code 0) with `fpu_en` set, every instruction class 0 to 7 gets a pass pulse, and the mode does not change.
- R3: With `exc_raise` high in execute mode, the mode becomes pending (code 1) and `fsr_ftt` takes `exc_type`, with no trap. `exc_raise` in pending or exception mode (code 2) has no effect.
- R4: In pending mode an FP operate (class 1) raises an fp-exception trap, moves the mode to exception and appends its {address, word} to the queue.
- R5: In exception mode an FP operate (1), FP load (2), FP branch (4) or load-status (5) raises an fp-exception trap, returns the mode to pending and sets `fsr_ftt` to sequence error (4), without a queue entry.
- R6: FP store (class 3) and store-status (class 6) pass in pending and exception modes and change neither the mode nor the queue.
- R7: A store-queue instruction (class 7) passes and removes the oldest queue entry. Removing the last entry in exception mode returns the mode to execute. On an empty queue it removes nothing.
- R8: With `fpu_en` clear, every class other than 0 gets the fp-disabled trap, whatever the mode, and leaves the mode, the queue and `fsr_ftt` unchanged.
- R9: Non-FP instructions (class 0) always pass and never change the mode.
- R10: The queue holds 4 entries and presents them oldest first. A new entry offered while it is full is dropped, and `q_overflow` is set and stays set until reset.
- R11: The verdict pulses and the mode and status updates appear in the cycle after the instruction is presented, with exactly one pulse per valid instruction and none without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is presented this cycle |
| in_cls | input | 3 | Instruction class code (0 non-FP .. 7 store-queue) |
| in_pc | input | ADDR_W | Instruction address |
| in_word | input | WORD_W | Instruction word |
| fpu_en | input | 1 | Floating-point unit enabled |
| exc_raise | input | 1 | Arithmetic unit reports an exception |
| exc_type | input | 3 | Trap-type code accompanying `exc_raise` |
| pass_pulse | output | 1 | Instruction may proceed |
| disabled_trap | output | 1 | fp-disabled trap |
| fpexc_trap | output | 1 | fp-exception trap |
| fpu_state | output | 2 | Mode: 0 execute, 1 pending, 2 exception |
| fsr_ftt | output | 3 | Status-register trap-type field |
| fsr_qne | output | 1 | Deferred queue not empty |
| q_overflow | output | 1 | Sticky: an entry was dropped on a full queue |
| q_head_pc | output | ADDR_W | Address of oldest queue entry |
| q_head_word | output | WORD_W | Instruction word of oldest queue entry |

## Verification
Every result of this block is due exactly one clock edge after the instruction or exception report that caused it. This covers the verdict pulse, the mode, the trap-type field, the queue flags and the queue head. The bench drives inputs on the falling edge. At the next falling edge it compares all outputs against a behavioural model that was advanced by that same stimulus, so each comparison lands one edge after its cause. Idle cycles are compared too, which catches a pulse that shows up late or lingers.

// File: rtl/fdx_pkg.sv
package fdx_pkg;

    typedef enum logic [2:0] {
        CLS_NONFP = 3'd0,
        CLS_FOP   = 3'd1,
        CLS_FLD   = 3'd2,
        CLS_FST   = 3'd3,
        CLS_FBR   = 3'd4,
        CLS_LDFSR = 3'd5,
        CLS_STFSR = 3'd6,
        CLS_STQ   = 3'd7
    } fdx_cls_e;

    typedef enum logic [1:0] {
        ST_EXEC = 2'd0,
        ST_PEND = 2'd1,
        ST_EXCP = 2'd2
    } fdx_state_e;

    typedef enum logic [1:0] {
        VD_NONE     = 2'd0,
        VD_PASS     = 2'd1,
        VD_DISABLED = 2'd2,
        VD_FPEXC    = 2'd3
    } fdx_verdict_e;

    localparam int FTT_W = 3;
    localparam logic [FTT_W-1:0] FTT_NONE    = 3'd0;
    localparam logic [FTT_W-1:0] FTT_SEQ_ERR = 3'd4;

    typedef struct packed {
        fdx_verdict_e verdict;
        fdx_state_e   nxt;
        logic         push;
        logic         pop;
        logic         seq_err;
        logic         take_exc;
    } fdx_decision_t;

    function automatic logic is_fp(fdx_cls_e c);
        return c != CLS_NONFP;
    endfunction

    function automatic logic is_seq_sensitive(fdx_cls_e c);
        return (c == CLS_FOP) || (c == CLS_FLD) || (c == CLS_FBR) || (c == CLS_LDFSR);
    endfunction

endpackage

// File: rtl/fdx_queue.sv
module fdx_queue #(
    parameter int DEPTH = 4,
    parameter int ENT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [ENT_W-1:0] push_data,
    output logic [ENT_W-1:0] head,
    output logic             empty,
    output logic             last,
    output logic             ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ENT_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt;
    logic             full, do_push, do_pop;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign last    = (cnt == CNT_W'(1));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slot[rd_ptr];

    function automatic logic [PTR_W-1:0] nxt_ptr(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot[i] <= '0;
                end else if (do_push && (wr_ptr == PTR_W'(i))) begin
                    slot[i] <= push_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= nxt_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= nxt_ptr(rd_ptr);
            if (do_push && !do_pop)      cnt <= cnt + CNT_W'(1);
            else if (do_pop && !do_push) cnt <= cnt - CNT_W'(1);
            if (push && full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/fdx_gate.sv
module fdx_gate
    import fdx_pkg::*;
(
    input  logic          in_valid,
    input  fdx_cls_e      cls,
    input  logic          fpu_en,
    input  logic          exc_raise,
    input  fdx_state_e    state,
    input  logic          q_empty,
    input  logic          q_last,
    output fdx_decision_t dec
);
    always_comb begin
        dec.verdict  = in_valid ? VD_PASS : VD_NONE;
        dec.nxt      = state;
        dec.push     = 1'b0;
        dec.pop      = 1'b0;
        dec.seq_err  = 1'b0;
        dec.take_exc = 1'b0;
        if (in_valid) begin
            if (is_fp(cls) && !fpu_en) begin
                dec.verdict = VD_DISABLED;
            end else begin
                if (state == ST_PEND && cls == CLS_FOP) begin
                    dec.verdict = VD_FPEXC;
                    dec.nxt     = ST_EXCP;
                    dec.push    = 1'b1;
                end else if (state == ST_EXCP && is_seq_sensitive(cls)) begin
                    dec.verdict = VD_FPEXC;
                    dec.nxt     = ST_PEND;
                    dec.seq_err = 1'b1;
                end
                if (cls == CLS_STQ && !q_empty) begin
                    dec.pop = 1'b1;
                    if (state == ST_EXCP && q_last) dec.nxt = ST_EXEC;
                end
            end
        end
        if (state == ST_EXEC && exc_raise) begin
            dec.nxt      = ST_PEND;
            dec.take_exc = 1'b1;
        end
    end
endmodule

// File: rtl/fpu_defer_ctrl.sv
module fpu_defer_ctrl
    import fdx_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WORD_W  = 32,
    parameter int Q_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        in_cls,
    input  logic [ADDR_W-1:0] in_pc,
    input  logic [WORD_W-1:0] in_word,
    input  logic              fpu_en,
    input  logic              exc_raise,
    input  logic [2:0]        exc_type,
    output logic              pass_pulse,
    output logic              disabled_trap,
    output logic              fpexc_trap,
    output logic [1:0]        fpu_state,
    output logic [2:0]        fsr_ftt,
    output logic              fsr_qne,
    output logic              q_overflow,
    output logic [ADDR_W-1:0] q_head_pc,
    output logic [WORD_W-1:0] q_head_word
);
    localparam int ENT_W = ADDR_W + WORD_W;

    fdx_state_e       state_q;
    fdx_decision_t    dec;
    logic             q_empty, q_last;
    logic [ENT_W-1:0] q_head;

    fdx_gate u_gate (
        .in_valid (in_valid),
        .cls      (fdx_cls_e'(in_cls)),
        .fpu_en   (fpu_en),
        .exc_raise(exc_raise),
        .state    (state_q),
        .q_empty  (q_empty),
        .q_last   (q_last),
        .dec      (dec)
    );

    fdx_queue #(.DEPTH(Q_DEPTH), .ENT_W(ENT_W)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (dec.push),
        .pop      (dec.pop),
        .push_data({in_pc, in_word}),
        .head     (q_head),
        .empty    (q_empty),
        .last     (q_last),
        .ovf      (q_overflow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_EXEC;
            fsr_ftt       <= FTT_NONE;
            pass_pulse    <= 1'b0;
            disabled_trap <= 1'b0;
            fpexc_trap    <= 1'b0;
        end else begin
            state_q       <= dec.nxt;
            pass_pulse    <= (dec.verdict == VD_PASS);
            disabled_trap <= (dec.verdict == VD_DISABLED);
            fpexc_trap    <= (dec.verdict == VD_FPEXC);
            if (dec.seq_err)       fsr_ftt <= FTT_SEQ_ERR;
            else if (dec.take_exc) fsr_ftt <= exc_type;
        end
    end

    assign fpu_state   = state_q;
    assign fsr_qne     = !q_empty;
    assign q_head_pc   = q_head[ENT_W-1:WORD_W];
    assign q_head_word = q_head[WORD_W-1:0];
endmodule

// File: rtl/fdx_checker.sv
module fdx_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [2:0] in_cls,
    input logic       fpu_en,
    input logic       pass_pulse,
    input logic       disabled_trap,
    input logic       fpexc_trap,
    input logic [1:0] fpu_state,
    input logic [2:0] fsr_ftt,
    input logic       fsr_qne,
    input logic       q_overflow
);
    // R11
    one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pass_pulse, disabled_trap, fpexc_trap}));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !(pass_pulse || disabled_trap || fpexc_trap));

    // R8
    disabled_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !fpu_en && in_cls != 3'd0) |=> (disabled_trap && $stable(fsr_qne)));

    // R9
    nonfp_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cls == 3'd0) |=> pass_pulse);

    // R5
    seq_error_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fpu_en && fpu_state == 2'd2 &&
         (in_cls == 3'd1 || in_cls == 3'd2 || in_cls == 3'd4 || in_cls == 3'd5))
        |=> (fpexc_trap && fpu_state == 2'd1 && fsr_ftt == 3'd4));

    // R6
    store_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fpu_en && fpu_state != 2'd0 && (in_cls == 3'd3 || in_cls == 3'd6))
        |=> (pass_pulse && $stable(fpu_state)));

    // R7
    qne_holds_mode_chk: assert property (@(posedge clk) disable iff (rst)
        fsr_qne |-> fpu_state != 2'd0);

    // R10
    no_overflow_clear_chk: assert property (@(posedge clk) disable iff (rst)
        q_overflow |=> q_overflow);
endmodule

bind fpu_defer_ctrl fdx_checker u_fdx_checker (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_cls       (in_cls),
    .fpu_en       (fpu_en),
    .pass_pulse   (pass_pulse),
    .disabled_trap(disabled_trap),
    .fpexc_trap   (fpexc_trap),
    .fpu_state    (fpu_state),
    .fsr_ftt      (fsr_ftt),
    .fsr_qne      (fsr_qne),
    .q_overflow   (q_overflow)
);

// File: tb/test_fpu_defer_ctrl.sv
`timescale 1ns/1ps
module test_fpu_defer_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_cls = 3'd0;
    logic [31:0] in_pc = '0;
    logic [31:0] in_word = '0;
    logic        fpu_en = 1'b1;
    logic        exc_raise = 1'b0;
    logic [2:0]  exc_type = 3'd0;
    logic        pass_pulse, disabled_trap, fpexc_trap;
    logic [1:0]  fpu_state;
    logic [2:0]  fsr_ftt;
    logic        fsr_qne, q_overflow;
    logic [31:0] q_head_pc, q_head_word;

    always #2.5 clk = ~clk;

    fpu_defer_ctrl i_fpu_defer_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls),
        .in_pc(in_pc), .in_word(in_word), .fpu_en(fpu_en),
        .exc_raise(exc_raise), .exc_type(exc_type),
        .pass_pulse(pass_pulse), .disabled_trap(disabled_trap),
        .fpexc_trap(fpexc_trap), .fpu_state(fpu_state), .fsr_ftt(fsr_ftt),
        .fsr_qne(fsr_qne), .q_overflow(q_overflow),
        .q_head_pc(q_head_pc), .q_head_word(q_head_word)
    );

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference
    int          m_state = 0;
    logic [2:0]  m_ftt = 3'd0;
    logic        m_ovf = 1'b0;
    logic [63:0] m_q[$];
    logic        e_pass = 0, e_dis = 0, e_exc = 0;
    string       prev_req = "R1";

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        check("R11", {req, " pass"}, 64'(pass_pulse), 64'(e_pass));
        check("R11", {req, " disabled"}, 64'(disabled_trap), 64'(e_dis));
        check("R11", {req, " fpexc"}, 64'(fpexc_trap), 64'(e_exc));
        check(req, "state", 64'(fpu_state), 64'(m_state));
        check(req, "ftt", 64'(fsr_ftt), 64'(m_ftt));
        check(req, "qne", 64'(fsr_qne), 64'(m_q.size() != 0));
        check(req, "overflow", 64'(q_overflow), 64'(m_ovf));
        if (m_q.size() != 0)
            check(req, "queue head", {q_head_pc, q_head_word}, m_q[0]);
    endtask

    task automatic model(logic v, logic [2:0] c, logic en, logic [31:0] pc,
                         logic [31:0] w, logic ex, logic [2:0] et);
        int old;
        old = m_state;
        e_pass = 0; e_dis = 0; e_exc = 0;
        if (v) begin
            if (c != 3'd0 && !en) begin
                e_dis = 1;
            end else begin
                if (old == 1 && c == 3'd1) begin
                    m_state = 2;
                    e_exc = 1;
                    if (m_q.size() < 4) m_q.push_back({pc, w});
                    else m_ovf = 1;
                end else if (old == 2 && (c == 3'd1 || c == 3'd2 || c == 3'd4 || c == 3'd5)) begin
                    m_state = 1;
                    m_ftt = 3'd4;
                    e_exc = 1;
                end else begin
                    e_pass = 1;
                end
                if (c == 3'd7 && m_q.size() != 0) begin
                    void'(m_q.pop_front());
                    if (old == 2 && m_q.size() == 0) m_state = 0;
                end
            end
        end
        if (old == 0 && ex) begin
            m_state = 1;
            m_ftt = et;
        end
    endtask

    // one cycle: compare results of the previous stimulus, then drive the next
    task automatic cyc(string req, logic v, logic [2:0] c, logic en,
                       logic [31:0] pc, logic [31:0] w, logic ex, logic [2:0] et);
        @(negedge clk);
        compare_all(prev_req);
        in_valid = v; in_cls = c; fpu_en = en; in_pc = pc; in_word = w;
        exc_raise = ex; exc_type = et;
        model(v, c, en, pc, w, ex, et);
        prev_req = req;
    endtask

    task automatic ins(string req, logic [2:0] c, logic [31:0] pc = 32'h0);
        cyc(req, 1'b1, c, 1'b1, pc, ~pc, 1'b0, 3'd0);
    endtask

    initial begin : watchdog
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare_all("R1");
        // R2 / R9: execute mode passes everything
        for (int k = 0; k < 8; k++) ins("R2", 3'(k));
        ins("R9", 3'd0);
        // R8: disabled unit traps every FP class in execute
        for (int k = 1; k < 8; k++) cyc("R8", 1'b1, 3'(k), 1'b0, 32'h0, 32'h0, 1'b0, 3'd0);
        cyc("R8", 1'b1, 3'd0, 1'b0, 32'h0, 32'h0, 1'b0, 3'd0);
        // R3: exception report, idle cycle, no trap
        cyc("R3", 1'b0, 3'd0, 1'b1, 32'h0, 32'h0, 1'b1, 3'd3);
        cyc("R11", 1'b0, 3'd0, 1'b1, 32'h0, 32'h0, 1'b0, 3'd0);
        // R6: stores and other FP pass in pending
        ins("R6", 3'd3); ins("R6", 3'd6); ins("R6", 3'd2); ins("R6", 3'd4);
        // R3: report in pending is ignored
        cyc("R3", 1'b1, 3'd0, 1'b1, 32'h0, 32'h0, 1'b1, 3'd6);
        // R4: first FP operate in pending traps and is queued
        ins("R4", 3'd1, 32'h1000);
        ins("R6", 3'd3); ins("R6", 3'd6); ins("R9", 3'd0);
        // R8 priority in exception mode
        cyc("R8", 1'b1, 3'd1, 1'b0, 32'h0, 32'h0, 1'b0, 3'd0);
        cyc("R8", 1'b1, 3'd3, 1'b0, 32'h0, 32'h0, 1'b0, 3'd0);
        cyc("R3", 1'b0, 3'd0, 1'b1, 32'h0, 32'h0, 1'b1, 3'd2);
        // R5 sequence errors alternating with R4 queueing, up to overflow (R10)
        ins("R5", 3'd2, 32'h0bad);
        ins("R4", 3'd1, 32'h1004);
        ins("R5", 3'd4);
        ins("R4", 3'd1, 32'h1008);
        ins("R5", 3'd5);
        ins("R4", 3'd1, 32'h100c);
        ins("R5", 3'd1, 32'h0bad);
        ins("R10", 3'd1, 32'h1010);
        ins("R10", 3'd0);
        // R7: drain in order, back to execute
        ins("R7", 3'd7); ins("R7", 3'd7); ins("R7", 3'd7); ins("R7", 3'd7);
        ins("R7", 3'd7);
        ins("R2", 3'd1);
        // R7: drain while pending keeps pending
        cyc("R3", 1'b0, 3'd0, 1'b1, 32'h0, 32'h0, 1'b1, 3'd5);
        ins("R4", 3'd1, 32'h2000);
        ins("R5", 3'd1);
        ins("R7", 3'd7);
        ins("R7", 3'd7);
        ins("R4", 3'd1, 32'h2004);
        ins("R7", 3'd7);
        cyc("R11", 1'b0, 3'd0, 1'b1, 32'h0, 32'h0, 1'b0, 3'd0);
        @(negedge clk);
        compare_all(prev_req);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule